// File: doc/BRIEF.md
# Multi-Agent Coherence Invariant Monitor

This block is a synthesizable checker that sits beside a coherent interconnect. Each caching agent reports every change of its access rights to a tracked line as one event: a line index and the agent's new line state. The monitor keeps its own shadow copy of every agent's state for every tracked line. After each batch of events it checks rules that span agents. At most one agent may hold a line with exclusive rights. At most one agent may carry write-back responsibility for a line. An agent built as a pure reader may never hold anything beyond a clean shared copy.

When a rule breaks, a sticky flag for that kind of violation goes high and stays high until reset. The first violation also records an error code and the index of the offending line. Each agent's event port is a valid/ready stream. The monitor never applies back-pressure once it is out of reset, so ready only guards the cycles around reset. The line state encoding is Invalid=0, UniqueClean=1, UniqueDirty=2, SharedClean=3, SharedDirty=4. Unique states are 1 and 2, dirty states are 2 and 4, and valid states are 1 to 4.

Top module: `coh_inv_monitor`

## Requirements
- R1: When two or more agents hold the same line in a unique state (codes 1 or 2) at once, err_flags bit 0 is set.
- R2: When two or more agents hold the same line in a dirty state (codes 2 or 4) at once, err_flags bit 1 is set.
- R3: When one agent holds a line in a unique state while at least one other agent holds that line in any valid state (codes 1 to 4), err_flags bit 2 is set.
- R4: An accepted event from an agent marked read-only in RO_MASK with new state 1, 2 or 4 sets err_flags bit 3. Codes 0 and 3 are legal for such an agent.
- R5: An accepted event with a state code above 4 sets err_flags bit 4, and the shadow entry is written as Invalid (0).
- R6: After reset, every shadow entry is Invalid and err_flags, err_any, err_code and err_line are all zero. The flags are sticky: once set, a bit stays set until reset.
- R7: On the first cycle in which any violation is detected, err_any rises and err_code captures 1 + the lowest set flag bit among that cycle's violations. err_line captures the line of that kind (the lowest line, or the line of the lowest-numbered agent for kinds 3 and 4). Neither changes afterward until reset.
- R8: Events from several agents accepted in the same cycle are applied together before checking. A same-cycle hand-off (one agent drops a line to Invalid while another takes it Unique) raises no flag.
- R9: An event accepted at clock edge k is reflected in err_flags right after edge k+1, and not after edge k.
- R10: upd_ready is low during reset and high for every agent from the first clock edge after reset onward. An event is taken only when valid and ready are both high, so events held during reset leave no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | N_AGENTS | Per-agent event valid |
| upd_ready | output | N_AGENTS | Per-agent event ready |
| upd_line | input | N_AGENTS*IDX_W | Per-agent line index, agent a at bits [a*IDX_W +: IDX_W] |
| upd_state | input | N_AGENTS*3 | Per-agent new line state, agent a at bits [a*3 +: 3] |
| err_flags | output | 5 | Sticky violation flags, bit k for the kind of R(k+1) |
| err_any | output | 1 | A violation has been seen since reset |
| err_code | output | 3 | 1 + kind of first violation, 0 when none |
| err_line | output | IDX_W | Line index of first violation |

## Verification
The bench builds the monitor with three agents, eight lines and agent 2 marked read-only. Three agents allow one batch of events to cause a sharing conflict on one line and a read-only breach on another line. That makes the kind-before-line order of the first-error capture observable. The read-only agent also gives a clean shared copy a third holder, so legal three-way sharing and same-cycle hand-offs can be shown to raise nothing.

// File: rtl/coh_mon_pkg.sv
package coh_mon_pkg;

  localparam int ST_W   = 3;
  localparam int N_KIND = 5;

  typedef enum logic [ST_W-1:0] {
    LS_INV = 3'd0,
    LS_UC  = 3'd1,
    LS_UD  = 3'd2,
    LS_SC  = 3'd3,
    LS_SD  = 3'd4
  } line_st_e;

  // violation kinds, also the flag bit positions
  localparam int K_TWO_UNIQ  = 0;
  localparam int K_TWO_DIRTY = 1;
  localparam int K_UNIQ_SHR  = 2;
  localparam int K_RO_BREACH = 3;
  localparam int K_BAD_CODE  = 4;

  function automatic logic st_unique(input logic [ST_W-1:0] s);
    return (s == LS_UC) || (s == LS_UD);
  endfunction

  function automatic logic st_dirty(input logic [ST_W-1:0] s);
    return (s == LS_UD) || (s == LS_SD);
  endfunction

  function automatic logic st_valid(input logic [ST_W-1:0] s);
    return (s != LS_INV) && (s <= LS_SD);
  endfunction

  function automatic logic st_legal(input logic [ST_W-1:0] s);
    return s <= LS_SD;
  endfunction

endpackage

// File: rtl/coh_shadow_table.sv
module coh_shadow_table
  import coh_mon_pkg::*;
#(
  parameter int             N_AGENTS = 3,
  parameter int             N_LINES  = 8,
  parameter int             IDX_W    = 3,
  parameter logic [N_AGENTS-1:0] RO_MASK = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_AGENTS-1:0]          take,
  input  logic [N_AGENTS*IDX_W-1:0]    ev_line,
  input  logic [N_AGENTS*ST_W-1:0]     ev_state,
  output logic [N_LINES*N_AGENTS*ST_W-1:0] table_flat,
  output logic [N_AGENTS-1:0]          ro_hit,
  output logic [N_AGENTS-1:0]          code_hit,
  output logic [N_AGENTS*IDX_W-1:0]    hit_line
);

  logic [ST_W-1:0]  shadow_q [N_LINES][N_AGENTS];
  logic [N_AGENTS-1:0] ro_q, code_q;
  logic [IDX_W-1:0] line_q [N_AGENTS];

  logic [N_AGENTS-1:0] bad_code, ro_bad;
  logic [ST_W-1:0]     wr_val [N_AGENTS];
  logic [IDX_W-1:0]    idx    [N_AGENTS];

  always_comb begin
    for (int a = 0; a < N_AGENTS; a++) begin
      idx[a]      = ev_line[a*IDX_W +: IDX_W];
      bad_code[a] = !st_legal(ev_state[a*ST_W +: ST_W]);
      wr_val[a]   = bad_code[a] ? LS_INV : ev_state[a*ST_W +: ST_W];
      ro_bad[a]   = RO_MASK[a] && (st_unique(ev_state[a*ST_W +: ST_W]) ||
                                   (ev_state[a*ST_W +: ST_W] == LS_SD));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < N_LINES; l++)
        for (int a = 0; a < N_AGENTS; a++)
          shadow_q[l][a] <= LS_INV;
      ro_q   <= '0;
      code_q <= '0;
      for (int a = 0; a < N_AGENTS; a++) line_q[a] <= '0;
    end else begin
      for (int a = 0; a < N_AGENTS; a++) begin
        if (take[a]) shadow_q[idx[a]][a] <= wr_val[a];
        ro_q[a]   <= take[a] && ro_bad[a];
        code_q[a] <= take[a] && bad_code[a];
        line_q[a] <= idx[a];
      end
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_ln
    for (genvar a = 0; a < N_AGENTS; a++) begin : g_ag
      assign table_flat[(l*N_AGENTS+a)*ST_W +: ST_W] = shadow_q[l][a];
    end
  end

  for (genvar a = 0; a < N_AGENTS; a++) begin : g_out
    assign hit_line[a*IDX_W +: IDX_W] = line_q[a];
  end
  assign ro_hit   = ro_q;
  assign code_hit = code_q;

endmodule

// File: rtl/coh_line_rules.sv
module coh_line_rules
  import coh_mon_pkg::*;
#(
  parameter int N_AGENTS = 3
) (
  input  logic [N_AGENTS*ST_W-1:0] line_st,
  output logic [2:0]               viol
);

  localparam int CNT_W = $clog2(N_AGENTS + 1);

  logic [CNT_W-1:0] n_uniq, n_dirty, n_valid;

  always_comb begin
    n_uniq  = '0;
    n_dirty = '0;
    n_valid = '0;
    for (int a = 0; a < N_AGENTS; a++) begin
      n_uniq  = n_uniq  + CNT_W'(st_unique(line_st[a*ST_W +: ST_W]));
      n_dirty = n_dirty + CNT_W'(st_dirty (line_st[a*ST_W +: ST_W]));
      n_valid = n_valid + CNT_W'(st_valid (line_st[a*ST_W +: ST_W]));
    end
    viol[K_TWO_UNIQ]  = n_uniq  > CNT_W'(1);
    viol[K_TWO_DIRTY] = n_dirty > CNT_W'(1);
    viol[K_UNIQ_SHR]  = (n_uniq != '0) && (n_valid > CNT_W'(1));
  end

endmodule

// File: rtl/coh_err_capture.sv
module coh_err_capture
  import coh_mon_pkg::*;
#(
  parameter int N_AGENTS = 3,
  parameter int N_LINES  = 8,
  parameter int IDX_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES*3-1:0]      line_viol,
  input  logic [N_AGENTS-1:0]       ro_hit,
  input  logic [N_AGENTS-1:0]       code_hit,
  input  logic [N_AGENTS*IDX_W-1:0] hit_line,
  output logic [N_KIND-1:0]         flags,
  output logic                      any,
  output logic [2:0]                code,
  output logic [IDX_W-1:0]          first_line
);

  logic [N_KIND-1:0] hit;
  logic [IDX_W-1:0]  kline [N_KIND];
  logic [2:0]        pick_code;
  logic [IDX_W-1:0]  pick_line;

  always_comb begin
    hit = '0;
    for (int k = 0; k < N_KIND; k++) kline[k] = '0;
    // table kinds: lowest line wins
    for (int k = 0; k < 3; k++) begin
      for (int l = N_LINES-1; l >= 0; l--) begin
        if (line_viol[l*3+k]) begin
          hit[k]   = 1'b1;
          kline[k] = IDX_W'(l);
        end
      end
    end
    // event kinds: lowest agent wins
    for (int a = N_AGENTS-1; a >= 0; a--) begin
      if (ro_hit[a]) begin
        hit[K_RO_BREACH]   = 1'b1;
        kline[K_RO_BREACH] = hit_line[a*IDX_W +: IDX_W];
      end
      if (code_hit[a]) begin
        hit[K_BAD_CODE]   = 1'b1;
        kline[K_BAD_CODE] = hit_line[a*IDX_W +: IDX_W];
      end
    end
    pick_code = '0;
    pick_line = '0;
    for (int k = N_KIND-1; k >= 0; k--) begin
      if (hit[k]) begin
        pick_code = 3'(k + 1);
        pick_line = kline[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags      <= '0;
      any        <= 1'b0;
      code       <= '0;
      first_line <= '0;
    end else begin
      flags <= flags | hit;
      if (!any && (hit != '0)) begin
        any        <= 1'b1;
        code       <= pick_code;
        first_line <= pick_line;
      end
    end
  end

endmodule

// File: rtl/coh_inv_monitor.sv
module coh_inv_monitor
  import coh_mon_pkg::*;
#(
  parameter int                  N_AGENTS = 3,
  parameter int                  N_LINES  = 8,
  parameter logic [N_AGENTS-1:0] RO_MASK  = '0,
  localparam int                 IDX_W    = $clog2(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_AGENTS-1:0]       upd_valid,
  output logic [N_AGENTS-1:0]       upd_ready,
  input  logic [N_AGENTS*IDX_W-1:0] upd_line,
  input  logic [N_AGENTS*3-1:0]     upd_state,
  output logic [4:0]                err_flags,
  output logic                      err_any,
  output logic [2:0]                err_code,
  output logic [IDX_W-1:0]          err_line
);

  logic                      rdy_q;
  logic [N_AGENTS-1:0]       take;
  logic [N_LINES*N_AGENTS*ST_W-1:0] table_flat;
  logic [N_LINES*3-1:0]      line_viol;
  logic [N_AGENTS-1:0]       ro_hit, code_hit;
  logic [N_AGENTS*IDX_W-1:0] hit_line;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign upd_ready = {N_AGENTS{rdy_q}};
  assign take      = upd_valid & upd_ready;

  coh_shadow_table #(
    .N_AGENTS(N_AGENTS), .N_LINES(N_LINES), .IDX_W(IDX_W), .RO_MASK(RO_MASK)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n), .take(take), .ev_line(upd_line),
    .ev_state(upd_state), .table_flat(table_flat), .ro_hit(ro_hit),
    .code_hit(code_hit), .hit_line(hit_line)
  );

  for (genvar l = 0; l < N_LINES; l++) begin : g_rule
    coh_line_rules #(.N_AGENTS(N_AGENTS)) u_rule (
      .line_st(table_flat[l*N_AGENTS*ST_W +: N_AGENTS*ST_W]),
      .viol   (line_viol[l*3 +: 3])
    );
  end

  coh_err_capture #(
    .N_AGENTS(N_AGENTS), .N_LINES(N_LINES), .IDX_W(IDX_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .line_viol(line_viol), .ro_hit(ro_hit),
    .code_hit(code_hit), .hit_line(hit_line), .flags(err_flags),
    .any(err_any), .code(err_code), .first_line(err_line)
  );

endmodule

// File: rtl/coh_inv_monitor_chk.sv
module coh_inv_monitor_chk #(
  parameter int N_AGENTS = 3,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_AGENTS-1:0] upd_ready,
  input logic [4:0]          err_flags,
  input logic                err_any,
  input logic [2:0]          err_code,
  input logic [IDX_W-1:0]    err_line
);

  // R6: flags never clear outside reset
  a_r6_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R7: captured code and line hold once a violation is recorded
  a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> ($stable(err_code) && $stable(err_line) && err_any));

  // R7: summary bit agrees with flag register
  a_r7_any_vs_flags: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == (err_flags != 5'd0));

  // R7: code names a kind whose flag is set
  a_r7_code_in_flags: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |-> (err_code >= 3'd1 && err_code <= 3'd5 && err_flags[err_code - 3'd1]));

  // R10: all agents see the same ready
  a_r10_ready_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(upd_ready) == 0) || ($countones(upd_ready) == N_AGENTS));

  // R10: ready stays high once up
  a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ready[0] |=> upd_ready[0]);

endmodule

bind coh_inv_monitor coh_inv_monitor_chk #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_ready(upd_ready), .err_flags(err_flags),
  .err_any(err_any), .err_code(err_code), .err_line(err_line)
);

// File: tb/sim_coh_inv_monitor.sv
`timescale 1ns/1ps
module sim_coh_inv_monitor;

  localparam int NA = 3;
  localparam int NL = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0] upd_valid = '0;
  logic [NA-1:0] upd_ready;
  logic [NA*IW-1:0] upd_line = '0;
  logic [NA*3-1:0]  upd_state = '0;
  logic [4:0]    err_flags;
  logic          err_any;
  logic [2:0]    err_code;
  logic [IW-1:0] err_line;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  coh_inv_monitor #(.N_AGENTS(NA), .N_LINES(NL), .RO_MASK(3'b100)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_line(upd_line), .upd_state(upd_state), .err_flags(err_flags),
    .err_any(err_any), .err_code(err_code), .err_line(err_line)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_err(input string req, input int fl, input int cd, input int ln);
    chk({req, " flags"}, int'(err_flags), fl);
    chk({req, " any"},   int'(err_any), (fl != 0) ? 1 : 0);
    chk({req, " code"},  int'(err_code), cd);
    chk({req, " line"},  int'(err_line), ln);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_valid = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int a, input int ln, input int st);
    upd_valid[a] = 1'b1;
    upd_line[a*IW +: IW] = IW'(ln);
    upd_state[a*3 +: 3]  = 3'(st);
  endtask

  // inputs staged at a negedge; returns after two further edges
  task automatic commit();
    @(negedge clk);
    upd_valid = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 ready in reset", int'(upd_ready), 0);
    chk_err("R6 reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", int'(upd_ready), 7);
  endtask

  task automatic t_share();
    do_reset();
    put(0, 1, 3); put(1, 1, 3); put(2, 1, 3); commit();
    put(0, 2, 4); put(1, 2, 3); commit();
    chk_err("R3 legal sharing", 0, 0, 0);
  endtask

  task automatic t_handoff();
    do_reset();
    put(0, 4, 1); commit();
    put(0, 4, 0); put(1, 4, 2); commit();
    chk_err("R8 same-cycle handoff", 0, 0, 0);
  endtask

  task automatic t_two_uniq();
    do_reset();
    put(0, 3, 1); commit();
    put(1, 3, 2); commit();
    chk_err("R1 two unique", 5, 1, 3);
  endtask

  task automatic t_two_dirty();
    do_reset();
    put(0, 7, 4); put(1, 7, 4);
    @(negedge clk);
    upd_valid = '0;
    chk("R9 not after first edge", int'(err_flags), 0);
    @(negedge clk);
    chk_err("R2 two dirty", 2, 2, 7);
  endtask

  task automatic t_uniq_shr();
    do_reset();
    put(0, 0, 2); commit();
    put(1, 0, 3); commit();
    chk_err("R3 unique with sharer", 4, 3, 0);
  endtask

  task automatic t_ro();
    do_reset();
    put(2, 2, 3); commit();
    chk_err("R4 read-only clean share ok", 0, 0, 0);
    put(2, 2, 1); commit();
    chk_err("R4 read-only unique", 8, 4, 2);
  endtask

  task automatic t_bad_code();
    do_reset();
    put(0, 6, 7); commit();
    chk_err("R5 bad code", 16, 5, 6);
    put(1, 6, 1); commit();
    chk("R5 stored as invalid", int'(err_flags), 16);
  endtask

  task automatic t_first();
    do_reset();
    put(0, 5, 4); put(1, 5, 4); commit();
    put(0, 1, 1); put(1, 1, 1); commit();
    chk_err("R7 first kept, R6 sticky", 7, 2, 5);
  endtask

  task automatic t_prio();
    do_reset();
    put(0, 6, 4); put(1, 6, 4); put(2, 1, 1); commit();
    chk_err("R7 kind priority", 10, 2, 6);
  endtask

  task automatic t_gate();
    @(negedge clk);
    rst_n = 1'b0;
    put(0, 2, 1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    upd_valid = '0;
    @(negedge clk);
    put(1, 2, 3); commit();
    chk_err("R10 event during reset ignored", 0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_share();
    t_handoff();
    t_two_uniq();
    t_two_dirty();
    t_uniq_shr();
    t_ro();
    t_bad_code();
    t_first();
    t_prio();
    t_gate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule